// File: doc/BRIEF.md
# Combined Ready/Data Serial Output Port

This block is the converter-side end of a two-wire read link. A single output line tells the host that a fresh 24-bit result is waiting, and the same line then carries that result bit by bit. The host supplies the serial clock. When the conversion core raises its completion strobe, the block captures the result word and pulls the line low. While the host toggles the serial clock, the block shifts the word out with the most significant bit first. When the last bit has been read, the line goes back high. A result can be read only once.

The block also keeps the host from reading a register that is about to change. It counts system clocks from each completion strobe. A fixed guard interval before the next strobe is due, it withdraws any unread result. A high power-down input releases the line. After power-down is released, the block holds the line high through a power-up delay and then a full settling period, and only then accepts results. A configuration change restarts the settling period immediately. Until settling ends, the line stays high, so any read in that time returns all ones. The serial clock comes from the host's own clock domain and is resynchronized before it is used.

Top module: `rdy_dout_port`

## Requirements
- R1: While reset is high, the line enable `dout_oe` is low and `dout_o` is 1.
- R2: When `pwr_down` is sampled high, `dout_oe` is low from the next clock onward. Any held result is dropped.
- R3: After `pwr_down` is sampled low, the line is enabled and high from the next clock. Completion strobes have no effect for `PWRUP_CYC + SETTLE_CYC` clocks.
- R4: A completion strobe accepted in the running state drives `dout_o` low on the following clock.
- R5: The word is sent MSB first. After the k-th falling edge of `sclk`, the line carries bit 24-k of the word, so bit 23 comes out first.
- R6: After the 24th rising edge of `sclk`, the line returns high. Further `sclk` pulses read only ones until a new result is accepted.
- R7: A completion strobe during a partial read discards the rest of the old word and pulls the line low. The next read returns the new word starting from its MSB.
- R8: An unread result is withdrawn, and the line driven high, once `CONV_PERIOD - GUARD_CYC` clocks have passed since the last strobe.
- R9: A `cfg_change` pulse drives the line high on the next clock. Strobes then have no effect for `SETTLE_CYC` clocks.
- R10: A read performed after a configuration change, and before a new result is accepted, returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_down | input | 1 | Power-down request; line released while high |
| cfg_change | input | 1 | One-clock pulse: rate, gain, channel or clock source changed |
| conv_done | input | 1 | One-clock conversion-complete strobe from the core |
| conv_data | input | WORD_W | Result word captured on `conv_done` |
| sclk | input | 1 | Host serial clock, asynchronous, idles high |
| dout_o | output | 1 | Combined ready / serial data value |
| dout_oe | output | 1 | Drive enable for the line; low means tristated |

## Verification
A wrong internal state shows up at the line within at most three system clocks of the event that should have changed it. Examples are a wrong phase, a shifter left armed, or a stale guard count. The failure appears as a ready level at the wrong time or a wrong bit on the next falling edge of `sclk`. A bad bit counter shows up as a line that stays low, or goes high, one bit early or late compared with the 24-bit frame. A bad settling or power-up counter shows up as a strobe that was accepted too early, or as a missing ready after the window has ended.

// File: rtl/rdyout_pkg.sv
package rdyout_pkg;

    typedef enum logic [1:0] {
        PH_OFF,
        PH_WAKE,
        PH_SETTLE,
        PH_RUN
    } phase_e;

    typedef enum logic [1:0] {
        WD_EMPTY,
        WD_ARMED,
        WD_SHIFT
    } word_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } sclk_evt_t;

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync
    import rdyout_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_async,
    output sclk_evt_t evt
);
    // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its delayed copy
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[SYNC_STAGES-1:0], sclk_async};
    end

    always_comb begin
        evt.fall = !chain[SYNC_STAGES-1] &&  chain[SYNC_STAGES];
        evt.rise =  chain[SYNC_STAGES-1] && !chain[SYNC_STAGES];
    end
endmodule

// File: rtl/power_sequencer.sv
module power_sequencer
    import rdyout_pkg::*;
#(
    parameter int PWRUP_CYC  = 100000,
    parameter int SETTLE_CYC = 4000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pwr_down,
    input  logic   cfg_change,
    output phase_e phase
);
    localparam int MAXC = (PWRUP_CYC > SETTLE_CYC) ? PWRUP_CYC : SETTLE_CYC;
    localparam int CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] WAKE_LOAD   = CW'(PWRUP_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LOAD = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_OFF;
            cnt   <= '0;
        end else if (pwr_down) begin
            phase <= PH_OFF;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_OFF: begin
                    phase <= PH_WAKE;
                    cnt   <= WAKE_LOAD;
                end
                PH_WAKE: begin
                    if (cnt == '0) begin
                        phase <= PH_SETTLE;
                        cnt   <= SETTLE_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (cfg_change)       cnt <= SETTLE_LOAD;
                    else if (cnt == '0)   phase <= PH_RUN;
                    else                  cnt <= cnt - 1'b1;
                end
                PH_RUN: begin
                    if (cfg_change) begin
                        phase <= PH_SETTLE;
                        cnt   <= SETTLE_LOAD;
                    end
                end
                default: begin
                    phase <= PH_OFF;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/update_guard.sv
module update_guard
    import rdyout_pkg::*;
#(
    parameter int CONV_PERIOD = 1000,
    parameter int GUARD_CYC   = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_done,
    output logic guard
);
    localparam int SW = cnt_width(CONV_PERIOD);
    localparam logic [SW-1:0] SAT = SW'(CONV_PERIOD);
    localparam logic [SW-1:0] LIM = SW'(CONV_PERIOD - GUARD_CYC);

    logic [SW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst)             since <= '0;
        else if (conv_done)  since <= '0;
        else if (since != SAT) since <= since + 1'b1;
    end

    assign guard = (since >= LIM);
endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import rdyout_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              guard,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_data,
    input  sclk_evt_t         evt,
    output logic              line
);
    localparam int BW = cnt_width(WORD_W);
    localparam logic [BW-1:0] LAST = BW'(WORD_W - 1);

    word_e             st;
    logic [WORD_W-1:0] sreg;
    logic              out_bit;
    logic [BW-1:0]     rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= WD_EMPTY;
            sreg    <= '1;
            out_bit <= 1'b1;
            rises   <= '0;
        end else if (phase != PH_RUN) begin
            st      <= WD_EMPTY;
            out_bit <= 1'b1;
            rises   <= '0;
        end else if (conv_done) begin
            st      <= WD_ARMED;
            sreg    <= conv_data;
            out_bit <= 1'b1;
            rises   <= '0;
        end else if (guard) begin
            st      <= WD_EMPTY;
            rises   <= '0;
        end else begin
            case (st)
                WD_ARMED: begin
                    if (evt.fall) begin
                        out_bit <= sreg[WORD_W-1];
                        sreg    <= {sreg[WORD_W-2:0], 1'b1};
                        st      <= WD_SHIFT;
                    end
                end
                WD_SHIFT: begin
                    if (evt.fall) begin
                        out_bit <= sreg[WORD_W-1];
                        sreg    <= {sreg[WORD_W-2:0], 1'b1};
                    end else if (evt.rise) begin
                        if (rises == LAST) begin
                            st    <= WD_EMPTY;
                            rises <= '0;
                        end else begin
                            rises <= rises + 1'b1;
                        end
                    end
                end
                default: st <= WD_EMPTY;
            endcase
        end
    end

    always_comb begin
        if (phase != PH_RUN)       line = 1'b1;
        else if (st == WD_ARMED)   line = 1'b0;
        else if (st == WD_SHIFT)   line = out_bit;
        else                       line = 1'b1;
    end
endmodule

// File: rtl/rdy_dout_port.sv
module rdy_dout_port
    import rdyout_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int PWRUP_CYC   = 100000,
    parameter int SETTLE_CYC  = 4000,
    parameter int CONV_PERIOD = 1000,
    parameter int GUARD_CYC   = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              cfg_change,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_data,
    input  logic              sclk,
    output logic              dout_o,
    output logic              dout_oe
);
    phase_e    phase;
    sclk_evt_t evt;
    logic      guard;

    sclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst        (rst),
        .sclk_async (sclk),
        .evt        (evt)
    );

    power_sequencer #(.PWRUP_CYC(PWRUP_CYC), .SETTLE_CYC(SETTLE_CYC)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .pwr_down   (pwr_down),
        .cfg_change (cfg_change),
        .phase      (phase)
    );

    update_guard #(.CONV_PERIOD(CONV_PERIOD), .GUARD_CYC(GUARD_CYC)) guard_i (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .guard     (guard)
    );

    word_shifter #(.WORD_W(WORD_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .guard     (guard),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .evt       (evt),
        .line      (dout_o)
    );

    assign dout_oe = (phase != PH_OFF);
endmodule

// File: rtl/rdy_dout_port_chk.sv
module rdy_dout_port_chk
    import rdyout_pkg::*;
#(
    parameter int CONV_PERIOD = 1000,
    parameter int GUARD_CYC   = 20
) (
    input logic   clk,
    input logic   rst,
    input logic   pwr_down,
    input logic   cfg_change,
    input logic   conv_done,
    input logic   dout_o,
    input logic   dout_oe,
    input phase_e phase
);
    localparam int GW = cnt_width(CONV_PERIOD);
    localparam logic [GW-1:0] GSAT = GW'(CONV_PERIOD);
    localparam logic [GW-1:0] GLIM = GW'(CONV_PERIOD - GUARD_CYC);

    logic [GW-1:0] gap;
    always_ff @(posedge clk) begin
        if (rst)              gap <= '0;
        else if (conv_done)   gap <= '0;
        else if (gap != GSAT) gap <= gap + 1'b1;
    end

    // R2
    pwr_release_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> !dout_oe);

    // R3
    wake_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_down) |=> (dout_oe && dout_o));

    // R4
    ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && phase == PH_RUN && !cfg_change && !pwr_down) |=> !dout_o);

    // R8
    guard_high_chk: assert property (@(posedge clk) disable iff (rst)
        (gap >= GLIM && !conv_done) |=> dout_o);

    // R9
    cfg_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_change && !pwr_down) |=> dout_o);
endmodule

bind rdy_dout_port rdy_dout_port_chk #(
    .CONV_PERIOD (CONV_PERIOD),
    .GUARD_CYC   (GUARD_CYC)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .pwr_down   (pwr_down),
    .cfg_change (cfg_change),
    .conv_done  (conv_done),
    .dout_o     (dout_o),
    .dout_oe    (dout_oe),
    .phase      (phase)
);

// File: tb/rdy_dout_port_tb_top.sv
module rdy_dout_port_tb_top;
    localparam int W  = 24;
    localparam int PW = 200;
    localparam int SE = 300;
    localparam int CP = 800;
    localparam int GC = 40;
    localparam int LIM = CP - GC;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pwr_down = 1'b1;
    logic         cfg_change = 1'b0;
    logic         conv_done = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         sclk = 1'b1;
    logic         dout_o;
    logic         dout_oe;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    rdy_dout_port #(
        .WORD_W(W), .PWRUP_CYC(PW), .SETTLE_CYC(SE),
        .CONV_PERIOD(CP), .GUARD_CYC(GC), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .cfg_change(cfg_change),
        .conv_done(conv_done), .conv_data(conv_data), .sclk(sclk),
        .dout_o(dout_o), .dout_oe(dout_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [W-1:0] d);
        conv_data = d;
        conv_done = 1'b1;
        step(1);
        conv_done = 1'b0;
    endtask

    task automatic cfg_pulse();
        cfg_change = 1'b1;
        step(1);
        cfg_change = 1'b0;
    endtask

    // host read of nbits; unread bit positions stay 1
    task automatic read_bits(input int nbits, output logic [W-1:0] got);
        got = '1;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            step(6);
            got[W-1-i] = dout_o;
            sclk = 1'b1;
            step(6);
        end
    endtask

    function automatic logic [W-1:0] exp_partial(input logic [W-1:0] d, input int k);
        logic [W-1:0] m;
        m = '1;
        m = m >> k;
        return d | m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;
        logic [W-1:0] d;
        logic [W-1:0] d2;
        int unsigned  mode;
        int           k;
        void'($urandom(32'd5150));

        step(3);
        check("R1 oe in reset", dout_oe, 0);
        check("R1 line in reset", dout_o, 1);
        rst = 1'b0;
        step(3);
        check("R2 oe while powered down", dout_oe, 0);

        pwr_down = 1'b0;
        step(1);
        check("R3 oe after release", dout_oe, 1);
        check("R3 line high after release", dout_o, 1);
        step(PW + SE - 20);
        strobe(24'h123456);
        check("R3 strobe ignored before settle end", dout_o, 1);
        step(30);

        d = 24'hA5C3F0;
        strobe(d);
        check("R4 ready low", dout_o, 0);
        read_bits(W, got);
        check("R5 directed word", got, d);
        step(1);
        check("R6 line high after word", dout_o, 1);
        read_bits(W, got);
        check("R6 second read all ones", got, 24'hFFFFFF);

        // MSB-only corner: 0x800000 then 0x000001
        strobe(24'h800000);
        read_bits(W, got);
        check("R5 MSB corner", got, 24'h800000);
        strobe(24'h000001);
        read_bits(W, got);
        check("R5 LSB corner", got, 24'h000001);

        for (int it = 0; it < 16; it++) begin
            d    = W'($urandom);
            d2   = W'($urandom);
            mode = $urandom % 4;
            case (mode)
                0: begin
                    strobe(d);
                    check("R4 ready low random", dout_o, 0);
                    read_bits(W, got);
                    check("R5 random word", got, d);
                    check("R6 high after random word", dout_o, 1);
                end
                1: begin
                    k = 1 + int'($urandom % 22);
                    strobe(d);
                    read_bits(k, got);
                    check("R7 partial prefix", got, exp_partial(d, k));
                    strobe(d2);
                    check("R7 re-armed low", dout_o, 0);
                    read_bits(W, got);
                    check("R7 new word from MSB", got, d2);
                end
                2: begin
                    strobe(d);
                    step(LIM - 5);
                    check("R8 still ready before guard", dout_o, 0);
                    step(10);
                    check("R8 withdrawn in guard", dout_o, 1);
                    read_bits(W, got);
                    check("R8 withdrawn read ones", got, 24'hFFFFFF);
                end
                default: begin
                    strobe(d);
                    cfg_pulse();
                    check("R9 high after cfg change", dout_o, 1);
                    strobe(d2);
                    check("R9 strobe ignored in settle", dout_o, 1);
                    read_bits(W, got);
                    check("R10 read after cfg all ones", got, 24'hFFFFFF);
                    step(SE);
                    strobe(d2);
                    check("R9 strobe accepted after settle", dout_o, 0);
                    read_bits(W, got);
                    check("R5 word after settle", got, d2);
                end
            endcase
        end

        // power-down during a pending result
        strobe(24'h0F0F0F);
        pwr_down = 1'b1;
        step(1);
        check("R2 oe low on power-down", dout_oe, 0);
        pwr_down = 1'b0;
        step(1);
        check("R3 line high on wake", dout_o, 1);
        step(PW + SE + 5);
        strobe(24'h3C3C3C);
        check("R4 ready after re-wake", dout_o, 0);
        read_bits(W, got);
        check("R5 word after re-wake", got, 24'h3C3C3C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule